// File: doc/BRIEF.md
# Depth-Chained FIFO Slice with Token Passing

This block is one storage slice of a first-in first-out buffer that is built deeper by linking several identical slices into a ring. All slices share one write strobe, one read strobe, the write data bus and a master reset. Each slice keeps its own small memory and two ownership bits: one for writing and one for reading. Only the slice that owns the write token accepts the shared write strobe. Only the slice that owns the read token accepts the shared read strobe. The other slices stay idle.

When the write owner stores a word into its highest address, it drops a single-cycle low pulse on its chain output. This passes write ownership to the next slice in the ring. Reading works the same way: the read owner pulses the same line when it reads out its highest address, and read ownership moves on. The receiving slice tells the two kinds of pulse apart by the strobe that is high in that cycle. The two strobes are never high together.

A strap input picks the slice that owns both tokens after master reset. Outputs are built so that a ring can be combined with plain OR gates: the read data and its valid bit are zero on every slice that did not read, and the active-low empty and full flags give a chain-wide "all empty" and "all full" when they are ORed.

Top module: `cascade_fifo_slice`

## Requirements
- R1: `mrst` is a synchronous, active-high reset. The first clock edge after it ends finds `empty_n`=0, `full_n`=1, `rd_valid`=0 and `xout_n`=1. A slice with `first_n`=0 then owns both tokens; a slice with `first_n`=1 owns neither.
- R2: A write is accepted only when the slice owns the write token, `wr_en`=1 and the slice is not full. Accepted words are stored at rising addresses that wrap from DEPTH-1 to 0.
- R3: A read is accepted only when the slice owns the read token, `rd_en`=1 and the slice is not empty. The oldest word appears on `rd_data` with `rd_valid`=1 one clock later. In every other cycle `rd_valid`=0 and `rd_data`=0.
- R4: A write strobe to a full slice that owns the write token is ignored: nothing is stored and the flags do not change.
- R5: A read strobe to an empty slice that owns the read token is ignored: `rd_valid` stays 0.
- R6: `xout_n` is low, in the same cycle as the strobe, exactly when an accepted write targets address DEPTH-1 or an accepted read takes address DEPTH-1. After that edge the slice no longer owns the token it passed on.
- R7: A slice that samples `xin_n`=0 at a clock edge takes the write token if `wr_en`=1 in that cycle, or the read token if `rd_en`=1. The strobes `wr_en` and `rd_en` are never high in the same cycle.
- R8: `empty_n` is low exactly when the slice holds no word. `full_n` is low exactly when it holds DEPTH words.
- R9: A ring of N slices acts as one FIFO of N*DEPTH words that keeps word order across slice borders and across ring wrap. The ORed `full_n` is low only when the whole ring is full, and the ORed `empty_n` is low only when it is empty.
- R10: Strobes that arrive while `mrst` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| mrst | input | 1 | Synchronous master reset, active high |
| first_n | input | 1 | Strap, low on the slice that is loaded first |
| xin_n | input | 1 | Token pulse from the previous slice, active low |
| wr_en | input | 1 | Shared write strobe |
| wr_data | input | DATA_W | Shared write data |
| rd_en | input | 1 | Shared read strobe |
| xout_n | output | 1 | Token pulse to the next slice, active low |
| rd_data | output | DATA_W | Read data, zero when not valid |
| rd_valid | output | 1 | High one cycle after an accepted read |
| empty_n | output | 1 | Low when the slice holds no word |
| full_n | output | 1 | Low when the slice holds DEPTH words |

## Verification
The embedded properties assume that the two shared strobes are mutually exclusive. Without that rule, a token pulse could not be decoded, and one property checks the rule directly. The bench never raises both strobes in one cycle and drives them only between clock edges. The properties also assume that the ring is closed, with every chain output wired to exactly one chain input. The bench builds a closed ring of three slices with exactly one slice strapped first. The strobes it applies to a full or empty ring are deliberate: they exercise the ignore rules, and the bench's own model predicts that those strobes are dropped.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
   // address width for a memory of the given depth, never below one bit
   function automatic int unsigned cfs_addr_bits(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

   // width of an occupancy counter that must reach the depth itself
   function automatic int unsigned cfs_count_bits(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/cfs_ptr.sv
module cfs_ptr #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned AW    = 2
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          step,
   output logic [AW-1:0] ptr,
   output logic          at_last
);
   localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
   localparam bit            POW2      = ((1 << AW) == DEPTH);

   assign at_last = (ptr == LAST_ADDR);

   generate
      if (POW2) begin : g_natural_wrap
         always_ff @(posedge clk) begin
            if (clr)       ptr <= '0;
            else if (step) ptr <= ptr + 1'b1;
         end
      end else begin : g_compare_wrap
         always_ff @(posedge clk) begin
            if (clr)       ptr <= '0;
            else if (step) ptr <= at_last ? '0 : ptr + 1'b1;
         end
      end
   endgenerate

   // a step taken from the top address lands on address zero
   p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (clr)
      (step && at_last) |=> (ptr == '0));
endmodule

// File: rtl/cfs_store.sv
module cfs_store #(
   parameter int unsigned DATA_W = 9,
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned AW     = 2
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   // zero when idle so that several slices can be merged with OR
   always_ff @(posedge clk) begin
      if (clr) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= re;
         rdata  <= re ? cells[raddr] : '0;
      end
   end
endmodule

// File: rtl/cfs_token.sv
module cfs_token (
   input  logic clk,
   input  logic mrst,
   input  logic first_n,
   input  logic xin_n,
   input  logic wr_en,
   input  logic rd_en,
   input  logic wr_last_acc,
   input  logic rd_last_acc,
   output logic tok_wr,
   output logic tok_rd,
   output logic xout_n
);
   logic take_wr, take_rd;

   // the strobe that is high beside the incoming pulse names the token
   assign take_wr = ~mrst & ~xin_n & wr_en;
   assign take_rd = ~mrst & ~xin_n & rd_en;
   assign xout_n  = ~(wr_last_acc | rd_last_acc);

   always_ff @(posedge clk) begin
      if (mrst) begin
         tok_wr <= ~first_n;
         tok_rd <= ~first_n;
      end else begin
         // the take term wins so that a ring of one slice keeps its tokens
         tok_wr <= (tok_wr & ~wr_last_acc) | take_wr;
         tok_rd <= (tok_rd & ~rd_last_acc) | take_rd;
      end
   end

   p_one_strobe_r7: assert property (@(posedge clk) disable iff (mrst)
      !(wr_en && rd_en));

   p_wr_release_r6: assert property (@(posedge clk) disable iff (mrst)
      (wr_last_acc && xin_n) |=> !tok_wr);

   p_rd_release_r6: assert property (@(posedge clk) disable iff (mrst)
      (rd_last_acc && xin_n) |=> !tok_rd);

   p_rd_take_r7: assert property (@(posedge clk) disable iff (mrst)
      (!xin_n && rd_en) |=> tok_rd);

   p_wr_take_r7: assert property (@(posedge clk) disable iff (mrst)
      (!xin_n && wr_en) |=> tok_wr);
endmodule

// File: rtl/cascade_fifo_slice.sv
module cascade_fifo_slice
   import cfs_pkg::*;
#(
   parameter int unsigned DATA_W = 9,
   parameter int unsigned DEPTH  = 4
) (
   input  logic              clk,
   input  logic              mrst,
   input  logic              first_n,
   input  logic              xin_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic              xout_n,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              empty_n,
   output logic              full_n
);
   localparam int unsigned    AW       = cfs_addr_bits(DEPTH);
   localparam int unsigned    CW       = cfs_count_bits(DEPTH);
   localparam logic [CW-1:0]  FULL_CNT = CW'(DEPTH);

   initial begin : chk_params
      assert (DEPTH >= 2)  else $error("cascade_fifo_slice: DEPTH must be at least 2");
      assert (DATA_W >= 1) else $error("cascade_fifo_slice: DATA_W must be at least 1");
   end

   logic          tok_wr, tok_rd;
   logic          wr_acc, rd_acc;
   logic          wr_at_last, rd_at_last;
   logic [AW-1:0] wr_addr, rd_addr;
   logic [CW-1:0] fill_q;
   logic          is_full, is_empty;

   assign is_full  = (fill_q == FULL_CNT);
   assign is_empty = (fill_q == '0);
   assign wr_acc   = ~mrst & tok_wr & wr_en & ~is_full;
   assign rd_acc   = ~mrst & tok_rd & rd_en & ~is_empty;
   assign empty_n  = ~is_empty;
   assign full_n   = ~is_full;

   always_ff @(posedge clk) begin
      if (mrst) fill_q <= '0;
      else begin
         case ({wr_acc, rd_acc})
            2'b10:   fill_q <= fill_q + 1'b1;
            2'b01:   fill_q <= fill_q - 1'b1;
            default: fill_q <= fill_q;
         endcase
      end
   end

   cfs_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wr_ptr (
      .clk(clk), .clr(mrst), .step(wr_acc), .ptr(wr_addr), .at_last(wr_at_last)
   );

   cfs_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rd_ptr (
      .clk(clk), .clr(mrst), .step(rd_acc), .ptr(rd_addr), .at_last(rd_at_last)
   );

   cfs_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
      .clk(clk), .clr(mrst),
      .we(wr_acc), .waddr(wr_addr), .wdata(wr_data),
      .re(rd_acc), .raddr(rd_addr),
      .rdata(rd_data), .rvalid(rd_valid)
   );

   cfs_token u_token (
      .clk(clk), .mrst(mrst), .first_n(first_n), .xin_n(xin_n),
      .wr_en(wr_en), .rd_en(rd_en),
      .wr_last_acc(wr_acc & wr_at_last),
      .rd_last_acc(rd_acc & rd_at_last),
      .tok_wr(tok_wr), .tok_rd(tok_rd), .xout_n(xout_n)
   );

   p_reset_state_r1: assert property (@(posedge clk) disable iff (mrst)
      $past(mrst) |-> (!empty_n && full_n && !rd_valid && xout_n));

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (mrst)
      (!full_n && wr_en) |=> !full_n);

   p_no_underflow_r5: assert property (@(posedge clk) disable iff (mrst)
      (!empty_n && rd_en) |=> !rd_valid);

   p_valid_owner_r3: assert property (@(posedge clk) disable iff (mrst)
      rd_valid |-> ($past(tok_rd) && $past(rd_en)));

   p_idle_zero_r3: assert property (@(posedge clk) disable iff (mrst)
      !rd_valid |-> (rd_data == '0));

   p_flags_excl_r8: assert property (@(posedge clk) disable iff (mrst)
      !(!empty_n && !full_n));
endmodule

// File: tb/cascade_fifo_slice_test.sv
module cascade_fifo_slice_test;
   localparam int DW    = 9;
   localparam int DEP   = 4;
   localparam int NSL   = 3;
   localparam int TOTAL = DEP * NSL;

   logic clk = 1'b0;
   logic mrst = 1'b1;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;

   logic [NSL-1:0] xo, rv, en, fn;
   logic [DW-1:0]  rdq [NSL];

   always #5 clk = ~clk;

   cascade_fifo_slice #(.DATA_W(DW), .DEPTH(DEP)) uut (
      .clk(clk), .mrst(mrst), .first_n(1'b0), .xin_n(xo[2]),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .xout_n(xo[0]), .rd_data(rdq[0]), .rd_valid(rv[0]), .empty_n(en[0]), .full_n(fn[0]));
   cascade_fifo_slice #(.DATA_W(DW), .DEPTH(DEP)) u_s1 (
      .clk(clk), .mrst(mrst), .first_n(1'b1), .xin_n(xo[0]),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .xout_n(xo[1]), .rd_data(rdq[1]), .rd_valid(rv[1]), .empty_n(en[1]), .full_n(fn[1]));
   cascade_fifo_slice #(.DATA_W(DW), .DEPTH(DEP)) u_s2 (
      .clk(clk), .mrst(mrst), .first_n(1'b1), .xin_n(xo[1]),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .xout_n(xo[2]), .rd_data(rdq[2]), .rd_valid(rv[2]), .empty_n(en[2]), .full_n(fn[2]));

   logic [DW-1:0] chain_data;
   assign chain_data = rdq[0] | rdq[1] | rdq[2];

   int n_checks = 0, n_fail = 0;
   logic [DW-1:0] model [$];
   logic [NSL-1:0] pre_xo;
   bit done = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one clock with the given strobes; pre_xo samples the chain lines before the edge
   task automatic cyc(input logic w, input logic r, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = w; rd_en = r; wr_data = d;
      #1 pre_xo = xo;
      @(posedge clk);
      #1;
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic do_write(input logic [DW-1:0] d);
      cyc(1'b1, 1'b0, d);
      if (model.size() < TOTAL) model.push_back(d);
   endtask

   task automatic do_read(input string req);
      cyc(1'b0, 1'b1, '0);
      if (model.size() > 0) begin
         check((rv != '0) && (chain_data == model[0]), req, int'(chain_data), int'(model[0]));
         check($countones(rv) == 1, {req, " single valid"}, $countones(rv), 1);
         void'(model.pop_front());
      end else begin
         check(rv == '0 && chain_data == '0, {req, " empty read ignored"}, int'(rv), 0);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); mrst = 1'b1;
      @(negedge clk); mrst = 1'b0;
      model.delete();
      @(posedge clk); #1;
   endtask

   task automatic t_reset();
      do_reset();
      check(en == '0, "R1 empty_n after reset", int'(en), 0);
      check(fn == '1, "R1 full_n after reset", int'(fn), 7);
      check(rv == '0 && xo == '1, "R1 valid and xout after reset", int'({rv, xo}), 7);
   endtask

   task automatic t_handoff();
      do_reset();
      for (int i = 0; i < DEP - 1; i++) do_write(DW'(16 + i));
      check(pre_xo[0] == 1'b1, "R6 no pulse before last address", int'(pre_xo[0]), 1);
      do_write(DW'(16 + DEP - 1));
      check(pre_xo == 3'b110, "R6 pulse on write of last address", int'(pre_xo), 6);
      check(fn[0] == 1'b0 && en[1] == 1'b0, "R8 first slice full, next still empty", int'({fn[0], en[1]}), 0);
      do_write(DW'(99));
      check(en[1] == 1'b1 && fn[0] == 1'b0, "R7 write token moved to next slice", int'({en[1], fn[0]}), 2);
      do_read("R3 read owner stays first slice");
      check(rv[0] == 1'b1, "R3 first slice supplies the oldest word", int'(rv), 1);
      check(fn[0] == 1'b1, "R8 full_n returns after a read", int'(fn[0]), 1);
   endtask

   task automatic t_full_empty();
      do_reset();
      for (int i = 0; i < TOTAL; i++) do_write(DW'(200 + i));
      check(fn == '0, "R9 whole ring full", int'(fn), 0);
      do_write(DW'(511));
      check(fn == '0 && en == '1, "R4 write to full ring ignored", int'({fn, en}), 7);
      for (int i = 0; i < TOTAL; i++) do_read("R9 ordered drain");
      check(en == '0, "R9 whole ring empty", int'(en), 0);
      do_read("R5");
      do_read("R5");
   endtask

   task automatic t_interleave();
      do_reset();
      for (int i = 0; i < 90; i++) begin
         if (((i * 7) % 5) < 3 && model.size() < TOTAL - 1) do_write(DW'(i * 3 + 1));
         else do_read("R2 wrap order");
      end
      while (model.size() > 0) do_read("R2 wrap drain");
      check(en == '0, "R8 empty after drain", int'(en), 0);
   endtask

   task automatic t_reset_mid();
      do_reset();
      for (int i = 0; i < 3; i++) do_write(DW'(40 + i));
      @(negedge clk); mrst = 1'b1; wr_en = 1'b1; wr_data = DW'(77);
      @(negedge clk);
      @(negedge clk); mrst = 1'b0; wr_en = 1'b0;
      model.delete();
      @(posedge clk); #1;
      check(en == '0 && rv == '0, "R10 strobes during reset ignored", int'({en, rv}), 0);
      do_write(DW'(5));
      check(en == 3'b001, "R1 first slice owns write token again", int'(en), 1);
      do_read("R1 read token back at first slice");
   endtask

   initial begin : watchdog
      #1_500_000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      t_reset();
      t_handoff();
      t_full_empty();
      t_interleave();
      t_reset_mid();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule